// File: doc/BRIEF.md
# Two-Level Maskable Handshake Error Register Block

This block collects handshake error events from a set of sources grouped into several second-level status registers. An event bit stays high while a source keeps its data-acknowledge signal raised too long. Each status bit latches such an event and stays set until software clears it. Each status register has its own mask register. The masked status of a group is OR-reduced into one pointer bit of a first-level summary register, so software can find the group that needs attention with a single read.

A summary mask selects which pointer bits may raise the single interrupt output. That output is registered. Software reaches every register through a simple read and write port. Read data comes back one cycle after the request. Status bits are cleared by writing a 1 to them. When the clear-on-read input is high, reading a status register also clears that whole register. An event that is present in the same cycle as any clear always wins.

Top module: `err_hier_regs`

## Requirements
- R1: After a synchronous reset, all status bits, mask bits, the summary mask, `irq_o` and `rdata_o` are 0.
- R2: A high event bit sets the matching status bit at the next clock edge. While the event stays high, the bit stays set even if a write-one-to-clear or a clear-on-read hits it in the same cycle.
- R3: Writing to a status register clears exactly the bits written as 1, provided their events are low. Bits written as 0 keep their value.
- R4: With `cor_en_i` = 1, reading a status register returns its value before the clear and then clears all its bits. With `cor_en_i` = 0, a read does not change the register.
- R5: Every group mask register and the summary mask register reset to 0 and read back the value last written to them. In the summary mask, only the bits at the pointer positions are stored.
- R6: The register map is as follows. Address 0 is the summary register. Address 1 is the summary mask. Addresses 2 to 2+N_GRP-1 are the status registers of groups 0 upward. The next N_GRP addresses are the group masks, in the same group order. In the summary register, bit DATA_W-N_GRP+g is the OR of the status of group g ANDed with the mask of group g. With the defaults, bits 7 to 4 belong to groups 3 to 0, and bits 3 to 0 read 0.
- R7: `irq_o` is 1 one cycle after the OR of the summary pointer bits ANDed with the summary mask is 1, and 0 one cycle after that OR is 0.
- R8: A write to the summary register (address 0) or to an unmapped address changes no register.
- R9: `rdata_o` takes the addressed register's value at the clock edge that samples `rd_en_i`, and holds its value when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_GRP*DATA_W | Error events, group g in bits g*DATA_W upward |
| cor_en_i | input | 1 | Clear-on-read enable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt |

## Verification
The hardest case to reach is a collision: a clear, either a write-one-to-clear or a clear-on-read, arriving in the very cycle in which the source still drives its event. The bench holds the event input high across the clearing write or read. It then reads the register again after the event has dropped, to show the bit survived. A second hard case is the one-cycle lag of the interrupt behind the pointer bits. The bench changes a group mask or clears a status bit, then samples `irq_o` both in the cycle right after that edge and in the cycle after that.

// File: rtl/err_hier_pkg.sv
package err_hier_pkg;
  // Kind of register selected by an address.
  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_SUM   = 3'd1,
    RK_SMASK = 3'd2,
    RK_STAT  = 3'd3,
    RK_MASK  = 3'd4
  } reg_kind_e;

  // Fixed offsets of the map; status and mask banks follow.
  localparam int unsigned SUM_OFS   = 0;
  localparam int unsigned SMASK_OFS = 1;
  localparam int unsigned STAT_OFS  = 2;
endpackage

// File: rtl/err_addr_dec.sv
module err_addr_dec
  import err_hier_pkg::*;
#(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [GIDX_W-1:0] grp_o
);
  localparam int unsigned MASK_OFS = STAT_OFS + N_GRP;
  localparam int unsigned END_OFS  = MASK_OFS + N_GRP;

  always_comb begin
    int unsigned a;
    a      = 32'(addr_i);
    kind_o = RK_NONE;
    grp_o  = '0;
    if (a == SUM_OFS) begin
      kind_o = RK_SUM;
    end else if (a == SMASK_OFS) begin
      kind_o = RK_SMASK;
    end else if (a >= STAT_OFS && a < MASK_OFS) begin
      kind_o = RK_STAT;
      grp_o  = GIDX_W'(a - STAT_OFS);
    end else if (a >= MASK_OFS && a < END_OFS) begin
      kind_o = RK_MASK;
      grp_o  = GIDX_W'(a - MASK_OFS);
    end
  end
endmodule

// File: rtl/err_stat_grp.sv
module err_stat_grp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              wr_stat_i,
  input  logic              wr_mask_i,
  input  logic              clr_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              ptr_o
);
  logic [DATA_W-1:0] stat_q, mask_q, clr_bits;

  // Bits that a write or a clearing read asks to drop this cycle.
  always_comb begin
    clr_bits = '0;
    if (wr_stat_i) clr_bits = wdata_i;
    if (clr_rd_i)  clr_bits = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      // A present event always overrides a clear.
      stat_q <= evt_i | (stat_q & ~clr_bits);
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign ptr_o  = |(stat_q & mask_q);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (!(wr_stat_i && (|wdata_i)) && !clr_rd_i) |=> (($past(stat_o) & ~stat_o) == '0));

  p_cor_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_rd_i && !(|evt_i)) |=> (stat_o == '0));

  p_mask_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_mask_i |=> $stable(mask_o));
endmodule

// File: rtl/err_summary.sv
module err_summary #(
  parameter int unsigned N_GRP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_GRP-1:0] ptr_i,
  input  logic             wr_smask_i,
  input  logic [N_GRP-1:0] wdata_i,
  output logic [N_GRP-1:0] smask_o,
  output logic             irq_o
);
  logic [N_GRP-1:0] smask_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smask_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_smask_i) smask_q <= wdata_i;
      irq_q <= |(ptr_i & smask_q);
    end
  end

  assign smask_o = smask_q;
  assign irq_o   = irq_q;

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (|(ptr_i & smask_o)) |=> irq_o);

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !(|(ptr_i & smask_o)) |=> !irq_o);
endmodule

// File: rtl/err_rd_mux.sv
module err_rd_mux
  import err_hier_pkg::*;
#(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en_i,
  input  reg_kind_e                    kind_i,
  input  logic [GIDX_W-1:0]            grp_i,
  input  logic [N_GRP-1:0][DATA_W-1:0] stat_i,
  input  logic [N_GRP-1:0][DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0]            sum_i,
  input  logic [DATA_W-1:0]            smask_i,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] sel, rdata_q;

  always_comb begin
    unique case (kind_i)
      RK_SUM:   sel = sum_i;
      RK_SMASK: sel = smask_i;
      RK_STAT:  sel = stat_i[grp_i];
      RK_MASK:  sel = mask_i[grp_i];
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/err_hier_regs.sv
module err_hier_regs
  import err_hier_pkg::*;
#(
  parameter int unsigned N_GRP  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_GRP*DATA_W-1:0] evt_i,
  input  logic                    cor_en_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    irq_o
);
  localparam int unsigned GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int unsigned PTR_LO = DATA_W - N_GRP;

  reg_kind_e                    kind;
  logic [GIDX_W-1:0]            grp;
  logic [N_GRP-1:0][DATA_W-1:0] stat_a, mask_a;
  logic [N_GRP-1:0]             ptr, smask;
  logic [DATA_W-1:0]            sum_val, smask_val;

  err_addr_dec #(.N_GRP(N_GRP), .ADDR_W(ADDR_W), .GIDX_W(GIDX_W)) dec_i (
    .addr_i (addr_i),
    .kind_o (kind),
    .grp_o  (grp)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    assign hit = (grp == GIDX_W'(g));
    err_stat_grp #(.DATA_W(DATA_W)) grp_i (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_i[g*DATA_W +: DATA_W]),
      .wr_stat_i (wr_en_i && kind == RK_STAT && hit),
      .wr_mask_i (wr_en_i && kind == RK_MASK && hit),
      .clr_rd_i  (rd_en_i && cor_en_i && kind == RK_STAT && hit),
      .wdata_i   (wdata_i),
      .stat_o    (stat_a[g]),
      .mask_o    (mask_a[g]),
      .ptr_o     (ptr[g])
    );
  end

  err_summary #(.N_GRP(N_GRP)) sum_i (
    .clk        (clk),
    .rst        (rst),
    .ptr_i      (ptr),
    .wr_smask_i (wr_en_i && kind == RK_SMASK),
    .wdata_i    (wdata_i[DATA_W-1:PTR_LO]),
    .smask_o    (smask),
    .irq_o      (irq_o)
  );

  // Pointer bits occupy the upper N_GRP bits; the rest read as zero.
  if (PTR_LO > 0) begin : g_lo
    assign sum_val   = {ptr, {PTR_LO{1'b0}}};
    assign smask_val = {smask, {PTR_LO{1'b0}}};
  end else begin : g_full
    assign sum_val   = ptr;
    assign smask_val = smask;
  end

  err_rd_mux #(.N_GRP(N_GRP), .DATA_W(DATA_W), .GIDX_W(GIDX_W)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (rd_en_i),
    .kind_i  (kind),
    .grp_i   (grp),
    .stat_i  (stat_a),
    .mask_i  (mask_a),
    .sum_i   (sum_val),
    .smask_i (smask_val),
    .rdata_o (rdata_o)
  );

  if (PTR_LO > 0) begin : g_chk_lo
    p_sum_lo_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_en_i && kind == RK_SUM) |=> (rdata_o[PTR_LO-1:0] == '0));
  end

  p_sum_wr_noeff_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (kind == RK_SUM || kind == RK_NONE)) |=> ($stable(stat_a) && $stable(mask_a) && $stable(smask)));
endmodule

// File: tb/err_hier_regs_tb_top.sv
`timescale 1ns/1ps
module err_hier_regs_tb_top;
  localparam int N_GRP = 4, DATA_W = 8, ADDR_W = 4;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        cor;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [31:0] evt;
    logic        chk;
    logic [7:0]  exp;
    logic [7:0]  req;
  } row_t;

  localparam int NROW = 22;
  localparam row_t VEC [NROW] = '{
    '{1'b0,1'b0,1'b0,4'd0,8'h00,32'h0000_0001,1'b0,8'h00,8'd2}, // R2 event g0 bit0
    '{1'b0,1'b1,1'b0,4'd2,8'h00,32'h0000_0000,1'b1,8'h01,8'd2}, // R2 latched
    '{1'b1,1'b0,1'b0,4'd2,8'h00,32'h0000_0000,1'b0,8'h00,8'd3}, // R3 write zeros
    '{1'b0,1'b1,1'b0,4'd2,8'h00,32'h0000_0000,1'b1,8'h01,8'd3}, // R3 kept
    '{1'b1,1'b0,1'b0,4'd6,8'h01,32'h0000_0000,1'b0,8'h00,8'd5}, // R5 mask g0
    '{1'b0,1'b1,1'b0,4'd6,8'h00,32'h0000_0000,1'b1,8'h01,8'd5}, // R5 readback
    '{1'b0,1'b1,1'b0,4'd0,8'h00,32'h0000_0000,1'b1,8'h10,8'd6}, // R6 ptr bit4
    '{1'b1,1'b0,1'b0,4'd2,8'h01,32'h0000_0000,1'b0,8'h00,8'd3}, // R3 w1c
    '{1'b0,1'b1,1'b0,4'd2,8'h00,32'h0000_0000,1'b1,8'h00,8'd3}, // R3 cleared
    '{1'b0,1'b1,1'b0,4'd0,8'h00,32'h0000_0000,1'b1,8'h00,8'd6}, // R6 ptr gone
    '{1'b0,1'b0,1'b0,4'd0,8'h00,32'h8000_0000,1'b0,8'h00,8'd2}, // R2 event g3 bit7
    '{1'b1,1'b0,1'b0,4'd5,8'h80,32'h8000_0000,1'b0,8'h00,8'd2}, // R2 w1c collides
    '{1'b0,1'b1,1'b0,4'd5,8'h00,32'h0000_0000,1'b1,8'h80,8'd2}, // R2 event won
    '{1'b1,1'b0,1'b0,4'd9,8'h80,32'h0000_0000,1'b0,8'h00,8'd6}, // R6 mask g3
    '{1'b0,1'b1,1'b0,4'd0,8'h00,32'h0000_0000,1'b1,8'h80,8'd6}, // R6 ptr bit7
    '{1'b0,1'b1,1'b1,4'd5,8'h00,32'h0000_0000,1'b1,8'h80,8'd4}, // R4 value before clear
    '{1'b0,1'b1,1'b0,4'd5,8'h00,32'h0000_0000,1'b1,8'h00,8'd4}, // R4 cleared
    '{1'b0,1'b0,1'b0,4'd0,8'h00,32'h0000_5A00,1'b0,8'h00,8'd2}, // R2 event g1
    '{1'b0,1'b1,1'b0,4'd3,8'h00,32'h0000_0000,1'b1,8'h5A,8'd4}, // R4 no clear
    '{1'b0,1'b1,1'b0,4'd3,8'h00,32'h0000_0000,1'b1,8'h5A,8'd4}, // R4 still there
    '{1'b1,1'b0,1'b0,4'd0,8'hFF,32'h0000_0000,1'b0,8'h00,8'd8}, // R8 write summary
    '{1'b0,1'b1,1'b0,4'd1,8'h00,32'h0000_0000,1'b1,8'h00,8'd8}  // R8 smask untouched
  };

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [N_GRP*DATA_W-1:0] evt = '0;
  logic                    cor = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0]       addr = '0;
  logic [DATA_W-1:0]       wdata = '0;
  logic [DATA_W-1:0]       rdata;
  logic                    irq;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  err_hier_regs #(.N_GRP(N_GRP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .cor_en_i(cor), .wr_en_i(wr),
    .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic step(input logic w, input logic r, input logic c,
                      input logic [3:0] a, input logic [7:0] d, input logic [31:0] e);
    wr = w; rd = r; cor = c; addr = a; wdata = d; evt = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    step(0,1,0,4'd6,8'h00,32'h0); check("R1 mask g0", rdata, 8'h00);
    step(0,1,0,4'd1,8'h00,32'h0); check("R1 smask", rdata, 8'h00);
    step(0,1,0,4'd2,8'h00,32'h0); check("R1 stat g0", rdata, 8'h00);

    // Table walk (R2..R9): rdata is valid one edge after the read (R9)
    for (int i = 0; i < NROW; i++) begin
      step(VEC[i].wr, VEC[i].rd, VEC[i].cor, VEC[i].addr, VEC[i].wdata, VEC[i].evt);
      if (VEC[i].chk)
        check($sformatf("R%0d row %0d", VEC[i].req, i), rdata, VEC[i].exp);
    end

    // R7 interrupt latency; g1 holds 5A from the table
    step(1,0,0,4'd1,8'h20,32'h0);
    step(1,0,0,4'd7,8'h02,32'h0);
    check("R7 irq lags mask", {7'd0, irq}, 8'h00);
    step(0,0,0,4'd0,8'h00,32'h0);
    check("R7 irq rises", {7'd0, irq}, 8'h01);
    step(0,1,0,4'd1,8'h00,32'h0);
    check("R5 smask readback", rdata, 8'h20);
    step(0,1,0,4'd0,8'h00,32'h0);
    check("R6 ptr bit5", rdata, 8'h20);
    step(1,0,0,4'd3,8'h02,32'h0);
    check("R7 irq lags clear", {7'd0, irq}, 8'h01);
    step(0,0,0,4'd0,8'h00,32'h0);
    check("R7 irq falls", {7'd0, irq}, 8'h00);
    step(0,1,0,4'd3,8'h00,32'h0);
    check("R3 only bit1 cleared", rdata, 8'h58);

    // R2/R4 clear-on-read colliding with a held event on g2 bit3
    step(0,0,0,4'd0,8'h00,32'h0008_0000);
    step(0,1,1,4'd4,8'h00,32'h0008_0000);
    check("R4 cor read value", rdata, 8'h08);
    step(0,1,0,4'd4,8'h00,32'h0);
    check("R2 event beats cor", rdata, 8'h08);
    step(0,1,1,4'd4,8'h00,32'h0);
    check("R4 cor read again", rdata, 8'h08);
    step(0,1,0,4'd4,8'h00,32'h0);
    check("R4 cleared by cor", rdata, 8'h00);

    // R8 write to unmapped address, R9 hold without read
    step(1,0,0,4'd15,8'hFF,32'h0);
    check("R9 rdata held", rdata, 8'h00);
    step(0,1,0,4'd6,8'h00,32'h0);
    check("R8 mask g0 untouched", rdata, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule